// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects a parameterised number of level-sensitive interrupt request lines, up to 128, and presents them to a processor as two request outputs: a normal request and a fast request. Each line has its own configuration word. A steering bit in that word picks which output the line feeds, and a 6-bit priority field ranks it against the other lines. A mask bitmap gates every line. Software can change the mask through a write-one-to-set alias, a write-one-to-clear alias or a direct write of a whole word.

Each output has its own sorter, built as a three-state machine. In `ST_WAIT` the output is low. When at least one unmasked line routed to that output is pending, the sorter takes a snapshot of those lines and moves to `ST_RANK` (transition *arm*). In `ST_RANK` it picks the winner from the snapshot, latches the winner's 7-bit line number, raises the output and moves to `ST_SERVE` (transition *grant*). It stays in `ST_SERVE` until software writes that output's acknowledge bit, then returns to `ST_WAIT` (transition *release*) and can sort again. Requests that arrive while the output is high do not disturb the published number. If the winning line stops pending before the acknowledge, the status reports a spurious flag instead of the line number.

Top module: `intc_top`

## Requirements
- R1: After reset every mask bit is 1 (masked), every configuration word reads 0 (normal output, priority 0), both outputs are low and both status words read 0.
- R2: The configuration word of line m sits at byte address 0x100+4m. Bit 0 is the steering bit (1 = fast, 0 = normal) and bits [7:2] hold the priority. All other bits are ignored on write and read as 0.
- R3: Mask word w covers lines 32w..32w+31 and has three addresses. A write to 0x080+4w replaces the word. A write to 0x0A0+4w sets the bits written as 1. A write to 0x0C0+4w clears the bits written as 1. On both aliases, bits written as 0 leave the mask unchanged. All three addresses read the current mask word.
- R4: A masked line never raises either output, whatever its level.
- R5: When an output is idle and an unmasked line routed to it is high at a rising edge, the output is high from the next rising edge after that one. It then stays high until acknowledged.
- R6: The winner is the pending line with the numerically smallest priority value. Among equal priorities, the lower line number wins. The status word for each output holds the winner number in bits [6:0]. The normal status is at 0x004 and the fast status at 0x008.
- R7: The two outputs sort independently. A line steered to one output never affects the other output's level or status.
- R8: Writing 1 to bit 0 (normal) or bit 1 (fast) at address 0x000 acknowledges that output. The output is low right after that edge. Until that write, the output level and the published number do not change. If requests are still pending, a new sort starts after the acknowledge.
- R9: If the winning line is no longer pending and unmasked while its output waits for the acknowledge, the status word reads 0x80: bit 7 is set and bits [6:0] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | N_LINES | Level-sensitive request lines |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_norm_o | output | 1 | Normal request output |
| irq_fast_o | output | 1 | Fast request output |

## Verification
The hardest case to reach from the ports is a change in the pending set while an output is already granted. A new higher-ranked line must leave the published number alone. A withdrawn winner must turn the status into the spurious code. Both must be observed before the acknowledge. Directed sequences raise a tying lower-numbered line and then drop it, all during `ST_SERVE`, and then acknowledge to show the re-sort. Seeded random rounds draw steering bits, priorities from a narrow range so that ties are frequent, and line patterns. The bench compares both outputs and both status words against a bench-side ranking function.

// File: rtl/intc_pkg.sv
package intc_pkg;
    typedef enum logic [1:0] {
        ST_WAIT  = 2'd0,
        ST_RANK  = 2'd1,
        ST_SERVE = 2'd2
    } sort_state_e;

    localparam int NUM_W     = 7;
    localparam int ADDR_W    = 12;
    localparam int DATA_W    = 32;
    localparam int A_CTRL    = 'h000;
    localparam int A_STAT_N  = 'h004;
    localparam int A_STAT_F  = 'h008;
    localparam int A_MASK    = 'h080;
    localparam int A_MSET    = 'h0A0;
    localparam int A_MCLR    = 'h0C0;
    localparam int A_CFG     = 'h100;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int PRIO_W  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_we,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    input  logic [7:0]            stat_norm,
    input  logic [7:0]            stat_fast,
    output logic [N_LINES-1:0]    mask_o,
    output logic [N_LINES-1:0]    route_o,
    output logic [N_LINES*PRIO_W-1:0] prio_o,
    output logic [1:0]            ack_o
);
    localparam int N_WORDS = (N_LINES + DATA_W - 1) / DATA_W;

    logic [N_WORDS*DATA_W-1:0]  mask_q;
    logic [N_LINES-1:0]         route_q;
    logic [N_LINES*PRIO_W-1:0]  prio_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '1;
            route_q <= '0;
            prio_q  <= '0;
        end else if (bus_we) begin
            for (int w = 0; w < N_WORDS; w++) begin
                if (bus_addr == ADDR_W'(A_MASK + 4*w))
                    mask_q[w*DATA_W +: DATA_W] <= bus_wdata;
                if (bus_addr == ADDR_W'(A_MSET + 4*w))
                    mask_q[w*DATA_W +: DATA_W] <= mask_q[w*DATA_W +: DATA_W] | bus_wdata;
                if (bus_addr == ADDR_W'(A_MCLR + 4*w))
                    mask_q[w*DATA_W +: DATA_W] <= mask_q[w*DATA_W +: DATA_W] & ~bus_wdata;
            end
            for (int m = 0; m < N_LINES; m++) begin
                if (bus_addr == ADDR_W'(A_CFG + 4*m)) begin
                    route_q[m]                  <= bus_wdata[0];
                    prio_q[m*PRIO_W +: PRIO_W]  <= bus_wdata[PRIO_W+1:2];
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_STAT_N)) bus_rdata = DATA_W'(stat_norm);
        if (bus_addr == ADDR_W'(A_STAT_F)) bus_rdata = DATA_W'(stat_fast);
        for (int w = 0; w < N_WORDS; w++) begin
            if (bus_addr == ADDR_W'(A_MASK + 4*w) ||
                bus_addr == ADDR_W'(A_MSET + 4*w) ||
                bus_addr == ADDR_W'(A_MCLR + 4*w))
                bus_rdata = mask_q[w*DATA_W +: DATA_W];
        end
        for (int m = 0; m < N_LINES; m++) begin
            if (bus_addr == ADDR_W'(A_CFG + 4*m))
                bus_rdata = (DATA_W'(prio_q[m*PRIO_W +: PRIO_W]) << 2) | DATA_W'(route_q[m]);
        end
    end

    assign ack_o[0] = bus_we && (bus_addr == ADDR_W'(A_CTRL)) && bus_wdata[0];
    assign ack_o[1] = bus_we && (bus_addr == ADDR_W'(A_CTRL)) && bus_wdata[1];
    assign mask_o   = mask_q[N_LINES-1:0];
    assign route_o  = route_q;
    assign prio_o   = prio_q;
endmodule

// File: rtl/intc_sorter.sv
module intc_sorter
    import intc_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int PRIO_W  = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_LINES-1:0]        req,
    input  logic [N_LINES*PRIO_W-1:0] prio,
    input  logic                      ack,
    output logic                      irq_o,
    output logic [NUM_W-1:0]          num_o,
    output logic [7:0]                status_o
);
    sort_state_e              state_q, state_d;
    logic [N_LINES-1:0]       snap_q;
    logic [NUM_W-1:0]         num_q;
    logic                     out_q;
    logic                     spur_q;
    logic [NUM_W-1:0]         win_idx;
    logic [PRIO_W-1:0]        win_prio;
    logic                     win_found;
    logic                     still_live;

    // ranking over the snapshot: strict less-than keeps the lower index on ties
    always_comb begin
        win_idx   = '0;
        win_prio  = '1;
        win_found = 1'b0;
        for (int i = 0; i < N_LINES; i++) begin
            if (snap_q[i] && (!win_found || prio[i*PRIO_W +: PRIO_W] < win_prio)) begin
                win_found = 1'b1;
                win_prio  = prio[i*PRIO_W +: PRIO_W];
                win_idx   = NUM_W'(i);
            end
        end
    end

    assign still_live = |(req & (N_LINES'(1) << num_q));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:  if (|req) state_d = ST_RANK;
            ST_RANK:  state_d = ST_SERVE;
            ST_SERVE: if (ack) state_d = ST_WAIT;
            default:  state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
            num_q  <= '0;
            out_q  <= 1'b0;
            spur_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_WAIT: begin
                    if (|req) snap_q <= req;
                end
                ST_RANK: begin
                    num_q  <= win_idx;
                    out_q  <= 1'b1;
                    spur_q <= 1'b0;
                end
                ST_SERVE: begin
                    if (ack)              out_q  <= 1'b0;
                    else if (!still_live) spur_q <= 1'b1;
                end
                default: out_q <= 1'b0;
            endcase
        end
    end

    assign irq_o    = out_q;
    assign num_o    = num_q;
    assign status_o = spur_q ? 8'h80 : {1'b0, num_q};
endmodule

// File: rtl/intc_top.sv
module intc_top
    import intc_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int PRIO_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_lines,
    input  logic               bus_we,
    input  logic [11:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_norm_o,
    output logic               irq_fast_o
);
    logic [N_LINES-1:0]        mask, route, pending;
    logic [N_LINES*PRIO_W-1:0] prio;
    logic [1:0]                ack_v, out_v, live_v;
    logic [2*NUM_W-1:0]        num_v;
    logic [15:0]               stat_v;

    intc_regs #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stat_norm(stat_v[7:0]), .stat_fast(stat_v[15:8]),
        .mask_o(mask), .route_o(route), .prio_o(prio), .ack_o(ack_v)
    );

    assign pending = irq_lines & ~mask;

    // output 0 takes lines steered with 0, output 1 those steered with 1
    for (genvar k = 0; k < 2; k++) begin : g_out
        logic [N_LINES-1:0] req_k;
        assign req_k     = (k == 0) ? (pending & ~route) : (pending & route);
        assign live_v[k] = |req_k;
        intc_sorter #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) u_sort (
            .clk(clk), .rst_n(rst_n), .req(req_k), .prio(prio), .ack(ack_v[k]),
            .irq_o(out_v[k]), .num_o(num_v[k*NUM_W +: NUM_W]),
            .status_o(stat_v[k*8 +: 8])
        );
    end

    assign irq_norm_o = out_v[0];
    assign irq_fast_o = out_v[1];
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
    parameter int N_LINES = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  out_v,
    input logic [1:0]  ack_v,
    input logic [1:0]  live_v,
    input logic [13:0] num_v
);
    for (genvar k = 0; k < 2; k++) begin : g_chk
        assert_onset_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(out_v[k]) |-> $past(live_v[k], 2));
        assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (out_v[k] && !ack_v[k]) |=> out_v[k]);
        assert_num_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (out_v[k] && !ack_v[k]) |=> $stable(num_v[k*7 +: 7]));
        assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (out_v[k] && ack_v[k]) |=> !out_v[k]);
        assert_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
            out_v[k] |-> (int'(num_v[k*7 +: 7]) < N_LINES));
    end
endmodule

bind intc_top intc_checker #(.N_LINES(N_LINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .out_v(out_v), .ack_v(ack_v),
    .live_v(live_v), .num_v(num_v)
);

// File: tb/test_intc_top.sv
module test_intc_top;
    localparam int N = 32;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [N-1:0] irq_lines = '0;
    logic        bus_we = 0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_norm_o, irq_fast_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic       route_m [N];
    logic [5:0] prio_m  [N];

    intc_top #(.N_LINES(N)) i_intc_top (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_norm_o(irq_norm_o), .irq_fast_o(irq_fast_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1;
        @(negedge clk);
        bus_we = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // bench ranking: smallest priority value, then lowest index
    function automatic int pick(input logic [N-1:0] sel);
        int best = -1;
        for (int i = 0; i < N; i++)
            if (sel[i] && (best < 0 || prio_m[i] < prio_m[best])) best = i;
        return best;
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) begin route_m[i] = 0; prio_m[i] = 0; end
        cyc(3); rst_n = 1; cyc(2);

        // R1 reset state
        chk(irq_norm_o == 0 && irq_fast_o == 0, "R1 outputs", {30'd0, irq_fast_o, irq_norm_o}, 0);
        rd(12'h080, d); chk(d == 32'hFFFF_FFFF, "R1 mask", d, 32'hFFFF_FFFF);
        rd(12'h114, d); chk(d == 0, "R1 cfg", d, 0);
        rd(12'h004, d); chk(d == 0, "R1 stat norm", d, 0);
        rd(12'h008, d); chk(d == 0, "R1 stat fast", d, 0);

        // R2 config layout, reserved bits dropped
        wr(12'h11C, 32'h8000_00AB);
        rd(12'h11C, d); chk(d == 32'hA9, "R2 cfg readback", d, 32'hA9);
        wr(12'h11C, 32'h0);

        // R3 mask aliases and direct write
        wr(12'h0C0, 32'h0000_000F); rd(12'h080, d); chk(d == 32'hFFFF_FFF0, "R3 clear", d, 32'hFFFF_FFF0);
        wr(12'h0A0, 32'h0000_0001); rd(12'h0A0, d); chk(d == 32'hFFFF_FFF1, "R3 set", d, 32'hFFFF_FFF1);
        wr(12'h0A0, 32'h0); rd(12'h0C0, d); chk(d == 32'hFFFF_FFF1, "R3 set zeros", d, 32'hFFFF_FFF1);
        wr(12'h0C0, 32'h0); rd(12'h080, d); chk(d == 32'hFFFF_FFF1, "R3 clear zeros", d, 32'hFFFF_FFF1);
        wr(12'h080, 32'h1234_5678); rd(12'h080, d); chk(d == 32'h1234_5678, "R3 direct", d, 32'h1234_5678);
        wr(12'h080, 32'hFFFF_FFFF);

        // R4 masked lines never raise an output
        @(negedge clk); irq_lines = '1; cyc(6);
        chk(irq_norm_o == 0 && irq_fast_o == 0, "R4 masked", {30'd0, irq_fast_o, irq_norm_o}, 0);
        irq_lines = '0;

        // R5 onset timing, line 5
        wr(12'h0C0, 32'h0000_0024);
        @(negedge clk); irq_lines[5] = 1;
        @(negedge clk); chk(irq_norm_o == 0, "R5 not yet", irq_norm_o, 0);
        @(negedge clk); chk(irq_norm_o == 1, "R5 raised", irq_norm_o, 1);
        rd(12'h004, d); chk(d == 5, "R6 single winner", d, 5);

        // R8 stability while granted: line 2 ties and is lower
        irq_lines[2] = 1; cyc(4);
        rd(12'h004, d); chk(d == 5 && irq_norm_o, "R8 number stable", d, 5);
        chk(irq_fast_o == 0, "R7 fast untouched", irq_fast_o, 0);
        wr(12'h000, 32'h1);
        chk(irq_norm_o == 0, "R8 ack drops", irq_norm_o, 0);
        @(negedge clk); @(negedge clk);
        chk(irq_norm_o == 1, "R8 re-sort", irq_norm_o, 1);
        rd(12'h004, d); chk(d == 2, "R6 tie lower index", d, 2);

        // R9 winner withdrawn before ack
        irq_lines[2] = 0; cyc(3);
        rd(12'h004, d); chk(d == 32'h80, "R9 spurious", d, 32'h80);
        wr(12'h000, 32'h1); cyc(2);
        rd(12'h004, d); chk(d == 5, "R8 re-sort after spurious", d, 5);
        irq_lines = '0; wr(12'h000, 32'h3);

        // R6/R7 random rounds
        wr(12'h080, 32'h0);
        for (int it = 0; it < 24; it++) begin
            logic [N-1:0] pat, rmask;
            int wn, wf;
            @(negedge clk); irq_lines = '0;
            wr(12'h000, 32'h3); cyc(2);
            rmask = '0;
            for (int i = 0; i < N; i++) begin
                route_m[i] = 1'($urandom_range(1, 0));
                prio_m[i]  = 6'($urandom_range(7, 0));
                rmask[i]   = route_m[i];
                wr(12'(12'h100 + 4*i), ({26'd0, prio_m[i]} << 2) | {31'd0, route_m[i]});
            end
            pat = (it % 5 == 4) ? (32'h1 << (it % N)) : 32'($urandom());
            wn = pick(pat & ~rmask);
            wf = pick(pat & rmask);
            @(negedge clk); irq_lines = pat; cyc(4);
            chk(irq_norm_o == (wn >= 0), "R7 normal level", irq_norm_o, (wn >= 0));
            chk(irq_fast_o == (wf >= 0), "R7 fast level", irq_fast_o, (wf >= 0));
            if (wn >= 0) begin rd(12'h004, d); chk(d == wn, "R6 normal winner", d, wn); end
            if (wf >= 0) begin rd(12'h008, d); chk(d == wf, "R6 fast winner", d, wf); end
        end
        @(negedge clk); irq_lines = '0;

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule